// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces horizontal sync, vertical sync and data-enable for an interlaced display raster. A pixel counter and a line counter both start at 0 on the first active pixel of the first active line. Every wrap of the line counter ends a field, and consecutive fields alternate between odd and even. Both fields run on one counter set. The odd field has one line more than the even field and its vertical sync window sits one line later. Its vertical sync edges also fall half a line earlier than the horizontal sync start, while the even field's edges line up with it. Because of this, the number of lines after vertical sync ends is the same in both fields.

Timing values arrive on configuration inputs. They are copied into shadow registers only when an even field ends, so a field never runs on a mix of old and new values. A progressive setting uses the even-field values for every field and stops the field flag from toggling. Every output is registered in one common stage. The reported pixel and line numbers therefore always match the sync and enable values shown with them.

Top module: `ilace_timing_gen`

## Requirements
- R1: `pix_o` counts 0 to h_total-1 and wraps to 0. `line_o` increments when `pix_o` wraps and returns to 0 after the field's last line. All outputs in a cycle describe the same raster position.
- R2: `hsync_o` is high exactly while hs_start <= `pix_o` < hs_end.
- R3: `de_o` is high exactly while `pix_o` < h_active and `line_o` < v_active.
- R4: `field_o` is 1 for the odd field and 0 for the even field. An even field has v_total lines and an odd field has v_total+1 lines. In interlaced mode the flag changes only at pixel 0 of line 0.
- R5: In the even field, `vsync_o` rises at (line vs_start, pixel hs_start) and falls at (line vs_stop, pixel hs_start).
- R6: In the odd field, `vsync_o` rises at (line vs_start+1, pixel hs_start - h_total/2) and falls at (line vs_stop+1, same pixel). This keeps the line count from vsync end to field end equal in both fields.
- R7: Configuration inputs take effect only from the first pixel after the last line of an even field. In progressive mode they take effect at every field end.
- R8: With the progressive setting loaded, every field has v_total lines, uses the even-field vsync placement, and `field_o` holds its value.
- R9: While `rst_ni` is low, hsync, vsync and data-enable are low, pixel and line are 0, and `field_o` is 1 (odd). The shadow registers hold the parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_h_active_i | input | CNT_W | Active pixels per line |
| cfg_h_total_i | input | CNT_W | Pixel clocks per line |
| cfg_hs_start_i | input | CNT_W | First pixel with hsync high |
| cfg_hs_end_i | input | CNT_W | First pixel with hsync low again |
| cfg_v_active_i | input | CNT_W | Active lines per field |
| cfg_v_total_i | input | CNT_W | Lines in an even field |
| cfg_vs_start_i | input | CNT_W | Even-field line where vsync rises |
| cfg_vs_stop_i | input | CNT_W | Even-field line where vsync falls |
| cfg_prog_i | input | 1 | 1 selects progressive operation |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | 1 odd field, 0 even field |
| pix_o | output | CNT_W | Pixel position of this cycle's outputs |
| line_o | output | CNT_W | Line position of this cycle's outputs |

## Verification
The shadow reload and the field flip happen on the same clock edge, at the last pixel of an even field's last line. The new field must start with both the new flag and the new values. The bench changes the configuration in the middle of an odd field. A reference model, stepped on every cycle, predicts the outputs. Its queued expectations show whether the old values were held through the whole even field and whether the new line total, sync window and field parity all start together at pixel 0 of line 0. A second run arms progressive mode the same way to check the case where the reload happens but the flag does not toggle.

// File: rtl/ilt_pkg.sv
package ilt_pkg;
  parameter int unsigned CNT_W = 12;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t h_active;
    cnt_t h_total;
    cnt_t hs_start;
    cnt_t hs_end;
    cnt_t v_active;
    cnt_t v_total;
    cnt_t vs_start;
    cnt_t vs_stop;
    logic prog;
  } tcfg_t;

  // per-field vertical set
  typedef struct packed {
    cnt_t vtotal;
    cnt_t vs_first;
    cnt_t vs_last;
    cnt_t vs_pix;
  } fld_t;
endpackage

// File: rtl/ilt_shadow.sv
module ilt_shadow
  import ilt_pkg::*;
#(
  parameter tcfg_t RST_CFG = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  tcfg_t cfg_i,
  output tcfg_t cfg_o
);
  tcfg_t shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shd_q <= RST_CFG;
    else if (load_i) shd_q <= cfg_i;
  end

  assign cfg_o = shd_q;
endmodule

// File: rtl/ilt_field_sel.sv
module ilt_field_sel
  import ilt_pkg::*;
(
  input  tcfg_t cfg_i,
  input  logic  odd_i,
  output fld_t  fld_o
);
  logic sel_odd;
  cnt_t half_line;

  assign sel_odd   = odd_i & ~cfg_i.prog;
  assign half_line = cnt_t'(cfg_i.h_total >> 1);

  // odd field: one extra line, window one line later, edge half a line early
  always_comb begin
    fld_o.vtotal   = cfg_i.v_total  + cnt_t'(sel_odd);
    fld_o.vs_first = cfg_i.vs_start + cnt_t'(sel_odd);
    fld_o.vs_last  = cfg_i.vs_stop  + cnt_t'(sel_odd);
    fld_o.vs_pix   = sel_odd ? cnt_t'(cfg_i.hs_start - half_line) : cfg_i.hs_start;
  end
endmodule

// File: rtl/ilt_counters.sv
module ilt_counters
  import ilt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t h_total_i,
  input  cnt_t v_total_i,
  input  logic prog_i,
  output cnt_t x_o,
  output cnt_t y_o,
  output logic odd_o,
  output logic load_o
);
  cnt_t x_q, y_q;
  logic odd_q;
  logic x_end, y_end;

  assign x_end = (x_q == cnt_t'(h_total_i - cnt_t'(1)));
  assign y_end = (y_q == cnt_t'(v_total_i - cnt_t'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q   <= '0;
      y_q   <= '0;
      odd_q <= 1'b1;
    end else if (x_end) begin
      x_q <= '0;
      if (y_end) begin
        y_q <= '0;
        if (!prog_i) odd_q <= ~odd_q;
      end else begin
        y_q <= y_q + cnt_t'(1);
      end
    end else begin
      x_q <= x_q + cnt_t'(1);
    end
  end

  // reload only after an even field (every field when progressive)
  assign load_o = x_end & y_end & (~odd_q | prog_i);
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign odd_o  = odd_q;
endmodule

// File: rtl/ilt_decode.sv
module ilt_decode
  import ilt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cnt_t  x_i,
  input  cnt_t  y_i,
  input  logic  odd_i,
  input  tcfg_t cfg_i,
  input  fld_t  fld_i,
  output logic  hsync_o,
  output logic  vsync_o,
  output logic  de_o,
  output logic  field_o,
  output cnt_t  pix_o,
  output cnt_t  line_o
);
  logic hs_on, vs_on, de_on, vs_after_rise, vs_before_fall;

  assign hs_on = (x_i >= cfg_i.hs_start) && (x_i < cfg_i.hs_end);
  assign de_on = (x_i < cfg_i.h_active) && (y_i < cfg_i.v_active);

  // vsync edges fall mid-line, compare line first then pixel
  assign vs_after_rise  = (y_i > fld_i.vs_first) ||
                          ((y_i == fld_i.vs_first) && (x_i >= fld_i.vs_pix));
  assign vs_before_fall = (y_i < fld_i.vs_last) ||
                          ((y_i == fld_i.vs_last) && (x_i < fld_i.vs_pix));
  assign vs_on = vs_after_rise && vs_before_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      field_o <= 1'b1;
      pix_o   <= '0;
      line_o  <= '0;
    end else begin
      hsync_o <= hs_on;
      vsync_o <= vs_on;
      de_o    <= de_on;
      field_o <= odd_i;
      pix_o   <= x_i;
      line_o  <= y_i;
    end
  end
endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
  import ilt_pkg::*;
#(
  parameter int unsigned DEF_H_ACTIVE = 1920,
  parameter int unsigned DEF_H_TOTAL  = 2640,
  parameter int unsigned DEF_HS_START = 2448,
  parameter int unsigned DEF_HS_END   = 2492,
  parameter int unsigned DEF_V_ACTIVE = 540,
  parameter int unsigned DEF_V_TOTAL  = 562,
  parameter int unsigned DEF_VS_START = 542,
  parameter int unsigned DEF_VS_STOP  = 548,
  parameter bit          DEF_PROG     = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [CNT_W-1:0] cfg_h_active_i,
  input  logic [CNT_W-1:0] cfg_h_total_i,
  input  logic [CNT_W-1:0] cfg_hs_start_i,
  input  logic [CNT_W-1:0] cfg_hs_end_i,
  input  logic [CNT_W-1:0] cfg_v_active_i,
  input  logic [CNT_W-1:0] cfg_v_total_i,
  input  logic [CNT_W-1:0] cfg_vs_start_i,
  input  logic [CNT_W-1:0] cfg_vs_stop_i,
  input  logic       cfg_prog_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       de_o,
  output logic       field_o,
  output logic [CNT_W-1:0] pix_o,
  output logic [CNT_W-1:0] line_o
);
  localparam tcfg_t RST_CFG = '{
    h_active: cnt_t'(DEF_H_ACTIVE), h_total:  cnt_t'(DEF_H_TOTAL),
    hs_start: cnt_t'(DEF_HS_START), hs_end:   cnt_t'(DEF_HS_END),
    v_active: cnt_t'(DEF_V_ACTIVE), v_total:  cnt_t'(DEF_V_TOTAL),
    vs_start: cnt_t'(DEF_VS_START), vs_stop:  cnt_t'(DEF_VS_STOP),
    prog:     DEF_PROG
  };

  tcfg_t cfg_in, shd_cfg;
  fld_t  fld;
  cnt_t  x, y;
  logic  odd, load;

  always_comb begin
    cfg_in.h_active = cfg_h_active_i;
    cfg_in.h_total  = cfg_h_total_i;
    cfg_in.hs_start = cfg_hs_start_i;
    cfg_in.hs_end   = cfg_hs_end_i;
    cfg_in.v_active = cfg_v_active_i;
    cfg_in.v_total  = cfg_v_total_i;
    cfg_in.vs_start = cfg_vs_start_i;
    cfg_in.vs_stop  = cfg_vs_stop_i;
    cfg_in.prog     = cfg_prog_i;
  end

  ilt_shadow #(.RST_CFG(RST_CFG)) u_shadow (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cfg_i (cfg_in),
    .cfg_o (shd_cfg)
  );

  ilt_field_sel u_fsel (
    .cfg_i(shd_cfg),
    .odd_i(odd),
    .fld_o(fld)
  );

  ilt_counters u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_total_i(shd_cfg.h_total),
    .v_total_i(fld.vtotal),
    .prog_i   (shd_cfg.prog),
    .x_o      (x),
    .y_o      (y),
    .odd_o    (odd),
    .load_o   (load)
  );

  ilt_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x),
    .y_i    (y),
    .odd_i  (odd),
    .cfg_i  (shd_cfg),
    .fld_i  (fld),
    .hsync_o(hsync_o),
    .vsync_o(vsync_o),
    .de_o   (de_o),
    .field_o(field_o),
    .pix_o  (pix_o),
    .line_o (line_o)
  );
endmodule

// File: rtl/ilt_checker.sv
module ilt_checker
  import ilt_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic field_i,
  input cnt_t pix_i,
  input cnt_t line_i,
  input logic prog_i
);
  AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i != '0) |-> (pix_i == cnt_t'($past(pix_i) + cnt_t'(1)))); // R1

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i != '0) |-> (line_i == $past(line_i))); // R1

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_i == '0 && $past(pix_i) != '0 && line_i != '0)
      |-> (line_i == cnt_t'($past(line_i) + cnt_t'(1)))); // R1

  AST_FIELD_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pix_i == '0 && line_i == '0) |-> $stable(field_i)); // R4

  AST_PROG_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && $past(prog_i) && $past(prog_i, 2)) |-> $stable(field_i)); // R8
endmodule

bind ilace_timing_gen ilt_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .field_i(field_o),
  .pix_i  (pix_o),
  .line_i (line_o),
  .prog_i (shd_cfg.prog)
);

// File: tb/ilace_timing_gen_tb.sv
module ilace_timing_gen_tb;
  import ilt_pkg::*;

  typedef struct {
    int ha, ht, hss, hse, va, vt, vss, vse;
    bit prog;
  } mcfg_t;

  typedef struct {
    bit hs, vs, de, fld;
    int pix, line;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  cnt_t cfg_h_active_i, cfg_h_total_i, cfg_hs_start_i, cfg_hs_end_i;
  cnt_t cfg_v_active_i, cfg_v_total_i, cfg_vs_start_i, cfg_vs_stop_i;
  logic cfg_prog_i;
  logic hsync_o, vsync_o, de_o, field_o;
  cnt_t pix_o, line_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  exp_t  q[$];
  mcfg_t ms;
  int    mx = 0, my = 0;
  bit    modd = 1'b1;

  always #5 clk_i = ~clk_i;

  ilace_timing_gen #(
    .DEF_H_ACTIVE(8), .DEF_H_TOTAL(20), .DEF_HS_START(12), .DEF_HS_END(14),
    .DEF_V_ACTIVE(4), .DEF_V_TOTAL(10), .DEF_VS_START(6),  .DEF_VS_STOP(8),
    .DEF_PROG(1'b0)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_h_active_i(cfg_h_active_i), .cfg_h_total_i(cfg_h_total_i),
    .cfg_hs_start_i(cfg_hs_start_i), .cfg_hs_end_i(cfg_hs_end_i),
    .cfg_v_active_i(cfg_v_active_i), .cfg_v_total_i(cfg_v_total_i),
    .cfg_vs_start_i(cfg_vs_start_i), .cfg_vs_stop_i(cfg_vs_stop_i),
    .cfg_prog_i(cfg_prog_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .field_o(field_o),
    .pix_o(pix_o), .line_o(line_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d (phase %s)", tag, "", act, exp, phase);
    end
  endtask

  task automatic set_cfg(input int ha, ht, hss, hse, va, vt, vss, vse, input bit pr);
    cfg_h_active_i = cnt_t'(ha);  cfg_h_total_i  = cnt_t'(ht);
    cfg_hs_start_i = cnt_t'(hss); cfg_hs_end_i   = cnt_t'(hse);
    cfg_v_active_i = cnt_t'(va);  cfg_v_total_i  = cnt_t'(vt);
    cfg_vs_start_i = cnt_t'(vss); cfg_vs_stop_i  = cnt_t'(vse);
    cfg_prog_i     = pr;
  endtask

  // reference: predicted outputs for raster position (mx,my)
  function automatic exp_t predict();
    exp_t e;
    bit   od;
    int   lt, rise, fall, pos;
    od   = modd && !ms.prog;
    pos  = my * 4096 + mx;
    rise = (ms.vss + (od ? 1 : 0)) * 4096 + (od ? ms.hss - ms.ht / 2 : ms.hss);
    fall = (ms.vse + (od ? 1 : 0)) * 4096 + (od ? ms.hss - ms.ht / 2 : ms.hss);
    e.hs   = (mx >= ms.hss) && (mx < ms.hse);
    e.de   = (mx < ms.ha) && (my < ms.va);
    e.vs   = (pos >= rise) && (pos < fall);
    e.fld  = modd;
    e.pix  = mx;
    e.line = my;
    lt = lt; // unused placeholder avoided below
    return e;
  endfunction

  task automatic model_step();
    int lines;
    lines = ms.vt + ((modd && !ms.prog) ? 1 : 0);
    if (mx == ms.ht - 1) begin
      mx = 0;
      if (my == lines - 1) begin
        my = 0;
        if (!modd || ms.prog) begin
          // R7: values sampled at even-field end
          ms.ha = int'(cfg_h_active_i); ms.ht = int'(cfg_h_total_i);
          ms.hss = int'(cfg_hs_start_i); ms.hse = int'(cfg_hs_end_i);
          ms.va = int'(cfg_v_active_i); ms.vt = int'(cfg_v_total_i);
          ms.vss = int'(cfg_vs_start_i); ms.vse = int'(cfg_vs_stop_i);
          if (!ms.prog) modd = ~modd;
          ms.prog = cfg_prog_i;
        end else begin
          modd = ~modd;
        end
      end else begin
        my++;
      end
    end else begin
      mx++;
    end
  endtask

  // scoreboard monitor: pop and compare, then push the next prediction
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 pix", int'(pix_o), e.pix);
      chk("R1 line", int'(line_o), e.line);
      chk("R2 hsync", int'(hsync_o), int'(e.hs));
      chk("R3 de", int'(de_o), int'(e.de));
      chk("R4 field", int'(field_o), int'(e.fld));
      if (e.fld && !ms.prog) chk("R6 vsync odd", int'(vsync_o), int'(e.vs));
      else                   chk("R5 vsync even", int'(vsync_o), int'(e.vs));
    end
    if (rst_ni && !done) begin
      q.push_back(predict());
      model_step();
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    ms = '{ha: 8, ht: 20, hss: 12, hse: 14, va: 4, vt: 10, vss: 6, vse: 8, prog: 1'b0};
    set_cfg(8, 20, 12, 14, 4, 10, 6, 8, 1'b0);
    repeat (3) @(negedge clk_i);
    // R9: reset state
    phase = "R9";
    chk("R9 hsync", int'(hsync_o), 0);
    chk("R9 vsync", int'(vsync_o), 0);
    chk("R9 de", int'(de_o), 0);
    chk("R9 field", int'(field_o), 1);
    chk("R9 pix", int'(pix_o), 0);
    chk("R9 line", int'(line_o), 0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    phase = "R1";
    // R7: change mid odd field, held until even field ends
    repeat (100) @(posedge clk_i); #1;
    phase = "R7";
    set_cfg(10, 24, 14, 17, 5, 9, 6, 7, 1'b0);
    repeat (800) @(posedge clk_i); #1;
    // R8: arm progressive, applies at next even end
    phase = "R8";
    set_cfg(10, 24, 14, 17, 5, 9, 6, 7, 1'b1);
    repeat (1100) @(posedge clk_i); #1;
    set_cfg(8, 20, 12, 14, 4, 10, 6, 8, 1'b0);
    repeat (1500) @(posedge clk_i); #1;
    done = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule